// File: doc/BRIEF.md
# Run-Queue Idle Power Controller

This block decides, cycle by cycle, which clocks of a processor subsystem may run. The CPU clock enable drops on its own whenever the thread scheduler reports that nothing is ready to run and no interrupt is waiting. It comes back as soon as an interrupt is pending or the scheduler has work again. No software sleep instruction is involved. The controller itself sits on a free-running clock. It drives only the enable inputs of clock-gate cells that live outside it.

A small register write port carries two things. The first is an enable mask with one bit per peripheral, which lets software turn off peripherals that are not in use. The second is a control word whose lowest bit orders a deep global stop. In that stop every enable output is low. Interrupts and the scheduler cannot end it; only an external active-low wake pin can. The wake pin passes through a synchronizer first. Because the logic is fully static, the gated clocks may stay stopped for any length of time without losing state. Every enable output comes straight from a flip-flop, so it changes only at a clock edge and cannot glitch at a gate cell.

Top module: `ipc_power_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `cpu_clk_en` is 1 and every bit of `periph_clk_en` is 1. The controller starts in the running state.
- R2: In the running state, if `runq_empty` is 1 and no bit of `irq_pend` is set at a clock edge, `cpu_clk_en` is 0 right after that edge, and the controller is idle.
- R3: In the running state, if any bit of `irq_pend` is set at an edge, `cpu_clk_en` stays 1, even when `runq_empty` is 1.
- R4: In the idle state, if `runq_empty` is 0 or any bit of `irq_pend` is set at an edge, `cpu_clk_en` is 1 right after that edge.
- R5: A write with `wr_addr`=0 loads `wr_data` into the peripheral mask. Outside global stop, `periph_clk_en` equals the new mask right after that edge, bit i controlling peripheral i. Idle does not clear the mask.
- R6: A write with `wr_addr`=1 and `wr_data[0]`=1 enters global stop from any state. This takes priority over every other condition. Right after that edge, `cpu_clk_en` and all bits of `periph_clk_en` are 0. A control write with `wr_data[0]`=0 has no effect.
- R7: In global stop, `irq_pend` and `runq_empty` are ignored. Once `wake_n` is held low, the outputs stay 0 for `SYNC_STAGES` edges. At the next edge the controller is running: `cpu_clk_en` is 1 and `periph_clk_en` equals the mask.
- R8: Mask writes made during global stop are kept, and the outputs stay 0 while the stop lasts. The new mask appears on `periph_clk_en` after the wake.
- R9: Outside global stop, `wake_n` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 1 | 0: peripheral mask, 1: control word |
| wr_data | input | N_PERIPH | Write data; bit 0 of the control word requests global stop |
| runq_empty | input | 1 | Scheduler reports no thread ready to run |
| irq_pend | input | N_IRQ | Pending interrupt lines |
| wake_n | input | 1 | Asynchronous active-low wake pin |
| cpu_clk_en | output | 1 | Registered enable for the CPU clock gate |
| periph_clk_en | output | N_PERIPH | Registered enables for the peripheral clock gates |

## Verification
The gating function is tried with random sequences of scheduler status, interrupt lines, mask writes and rare stop writes. A cycle-stepped model computes the expected state, which separates a correct idle decision from one that ignores interrupts or that reacts to the scheduler while stopped. Directed runs hold `wake_n` low outside global stop, which tells a properly qualified wake apart from one that leaks into the running state. They also write the mask during a stop and count the edges to wake-up, which exposes a wrong synchronizer depth or a lost mask value.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_STOP = 2'd2
  } gate_state_e;
endpackage

// File: rtl/ipc_wake_sync.sv
// Synchronizes the asynchronous wake pin; the idle level (high) is the reset value.
module ipc_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ipc_gate_fsm.sv
// Run / idle / stop decision. A stop request outranks everything else.
module ipc_gate_fsm
  import ipc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        runq_empty,
  input  logic        irq_any,
  input  logic        stop_req,
  input  logic        wake_sync_n,
  output gate_state_e state_q,
  output gate_state_e state_d
);
  always_comb begin
    state_d = state_q;
    if (stop_req) begin
      state_d = ST_STOP;
    end else begin
      unique case (state_q)
        ST_RUN:  if (runq_empty && !irq_any) state_d = ST_IDLE;
        ST_IDLE: if (!runq_empty || irq_any) state_d = ST_RUN;
        ST_STOP: if (!wake_sync_n)           state_d = ST_RUN;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/ipc_enable_regs.sv
// Peripheral mask plus the output flops; outputs follow the next state so
// they switch on the same edge as the state register.
module ipc_enable_regs
  import ipc_pkg::*;
#(
  parameter int N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mask_we,
  input  logic [N_PERIPH-1:0] mask_wdata,
  input  gate_state_e         state_d,
  output logic                cpu_en_q,
  output logic [N_PERIPH-1:0] periph_en_q
);
  logic [N_PERIPH-1:0] mask_q;
  logic [N_PERIPH-1:0] mask_d;
  logic                stop_next;

  assign mask_d    = mask_we ? mask_wdata : mask_q;
  assign stop_next = (state_d == ST_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      cpu_en_q <= 1'b1;
    end else begin
      mask_q   <= mask_d;
      cpu_en_q <= (state_d == ST_RUN);
    end
  end

  generate
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_pen
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) periph_en_q[i] <= 1'b1;
        else        periph_en_q[i] <= mask_d[i] & ~stop_next;
      end
    end
  endgenerate
endmodule

// File: rtl/ipc_power_ctrl.sv
module ipc_power_ctrl
  import ipc_pkg::*;
#(
  parameter int N_PERIPH    = 8,
  parameter int N_IRQ       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_addr,
  input  logic [N_PERIPH-1:0] wr_data,
  input  logic                runq_empty,
  input  logic [N_IRQ-1:0]    irq_pend,
  input  logic                wake_n,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en
);
  logic        mask_we;
  logic        stop_req;
  logic        irq_any;
  logic        wake_sync_n;
  gate_state_e state_q;
  gate_state_e state_d;

  assign mask_we  = wr_en && (wr_addr == 1'b0);
  assign stop_req = wr_en && (wr_addr == 1'b1) && wr_data[0];
  assign irq_any  = |irq_pend;

  ipc_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (wake_n),
    .sync_n (wake_sync_n)
  );

  ipc_gate_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .runq_empty  (runq_empty),
    .irq_any     (irq_any),
    .stop_req    (stop_req),
    .wake_sync_n (wake_sync_n),
    .state_q     (state_q),
    .state_d     (state_d)
  );

  ipc_enable_regs #(.N_PERIPH(N_PERIPH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_we     (mask_we),
    .mask_wdata  (wr_data),
    .state_d     (state_d),
    .cpu_en_q    (cpu_clk_en),
    .periph_en_q (periph_clk_en)
  );
endmodule

// File: rtl/ipc_power_ctrl_chk.sv
module ipc_power_ctrl_chk
  import ipc_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int N_IRQ    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                wr_addr,
  input logic [N_PERIPH-1:0] wr_data,
  input logic                runq_empty,
  input logic [N_IRQ-1:0]    irq_pend,
  input logic                cpu_clk_en,
  input logic [N_PERIPH-1:0] periph_clk_en,
  input gate_state_e         state_q
);
  logic stop_wr;
  assign stop_wr = wr_en && wr_addr && wr_data[0];

  p_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && runq_empty && !(|irq_pend) && !stop_wr)
    |=> (!cpu_clk_en && state_q == ST_IDLE));

  p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && (|irq_pend) && !stop_wr) |=> cpu_clk_en);

  p_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && (!runq_empty || (|irq_pend)) && !stop_wr) |=> cpu_clk_en);

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && state_q != ST_STOP) |=> (periph_clk_en == $past(wr_data)));

  p_stop_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (!cpu_clk_en && periph_clk_en == '0));

  p_stop_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (!cpu_clk_en && periph_clk_en == '0));

  p_stop_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_STOP && state_q != ST_STOP) |-> (state_q == ST_RUN && cpu_clk_en));
endmodule

bind ipc_power_ctrl ipc_power_ctrl_chk #(.N_PERIPH(N_PERIPH), .N_IRQ(N_IRQ)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .runq_empty    (runq_empty),
  .irq_pend      (irq_pend),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .state_q       (state_q)
);

// File: tb/tb_ipc_power_ctrl.sv
`timescale 1ns/1ps
module tb_ipc_power_ctrl;
  localparam int NP = 8;
  localparam int NI = 4;
  localparam int SS = 2;
  localparam int MAX_CYC = 20000;
  localparam int M_RUN = 0, M_IDLE = 1, M_STOP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [NP-1:0] wr_data = '0;
  logic          runq_empty = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic          wake_n = 1'b1;
  logic          cpu_clk_en;
  logic [NP-1:0] periph_clk_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model
  int          m_state = M_RUN;
  logic [SS-1:0] m_sync = '1;
  logic [NP-1:0] m_mask = '1;

  always #2 clk = ~clk;

  ipc_power_ctrl #(.N_PERIPH(NP), .N_IRQ(NI), .SYNC_STAGES(SS)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .runq_empty(runq_empty), .irq_pend(irq_pend), .wake_n(wake_n),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en)
  );

  function automatic int next_state(int st, logic stopw, logic empty, logic irq, logic wsync);
    if (stopw) return M_STOP;
    case (st)
      M_RUN:  return (empty && !irq) ? M_IDLE : M_RUN;
      M_IDLE: return (!empty || irq) ? M_RUN : M_IDLE;
      default: return (!wsync) ? M_RUN : M_STOP;
    endcase
  endfunction

  task automatic compare(string tag);
    logic          e_cpu;
    logic [NP-1:0] e_per;
    e_cpu = (m_state == M_RUN);
    e_per = (m_state == M_STOP) ? '0 : m_mask;
    n_chk++;
    if (cpu_clk_en !== e_cpu || periph_clk_en !== e_per) begin
      n_bad++;
      $display("FAIL %s: cpu=%b per=%h expected cpu=%b per=%h", tag, cpu_clk_en, periph_clk_en, e_cpu, e_per);
    end
  endtask

  // inputs are set at the negedge before calling; one edge is applied and checked
  task automatic step(string tag);
    logic stopw;
    @(posedge clk);
    stopw = wr_en && wr_addr && wr_data[0];
    m_state = next_state(m_state, stopw, runq_empty, |irq_pend, m_sync[SS-1]);
    if (wr_en && !wr_addr) m_mask = wr_data;
    m_sync = {m_sync[SS-2:0], wake_n};
    #1;
    compare(tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(MAX_CYC * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare("R1");
    @(negedge clk);

    // R3: interrupt pending keeps CPU running despite empty queue
    runq_empty = 1'b1; irq_pend = 4'b0100;
    step("R3"); step("R3");
    // R2: queue empty, no interrupt -> idle
    irq_pend = '0;
    step("R2"); step("R2");
    // R5: mask write in idle is visible
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'hA5;
    step("R5");
    // R4: interrupt wakes CPU
    irq_pend = 4'b0001;
    step("R4");
    irq_pend = '0;
    step("R2");
    runq_empty = 1'b0;
    step("R4");
    // R9: wake pin outside stop has no effect
    wake_n = 1'b0;
    for (int i = 0; i < 4; i++) step("R9");
    wake_n = 1'b1;
    for (int i = 0; i < 3; i++) step("R9");
    // R6: control write with bit0 clear does nothing
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'hFE;
    step("R6");
    // R6: stop entry
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h01;
    step("R6");
    // R7: interrupts and queue ignored while stopped
    irq_pend = 4'b1111; runq_empty = 1'b0;
    step("R7"); step("R7");
    // R8: mask write during stop retained, outputs dark
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h3C;
    step("R8");
    irq_pend = '0;
    wake_n = 1'b0;
    for (int i = 0; i < SS; i++) step("R7");
    step("R8");
    wake_n = 1'b1;
    step("R8");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      string tag;
      runq_empty = ($urandom % 3) != 0;
      irq_pend   = (($urandom % 4) == 0) ? NI'($urandom) : '0;
      wake_n     = ($urandom % 8) != 0;
      wr_en      = ($urandom % 8) == 0;
      wr_addr    = ($urandom % 6) == 0;
      wr_data    = NP'($urandom);
      tag = (m_state == M_RUN) ? "R2" : (m_state == M_IDLE) ? "R4" : "R7";
      if (wr_en && !wr_addr) tag = "R5";
      if (wr_en && wr_addr) tag = "R6";
      step(tag);
    end
    summary();
  end
endmodule